// File: doc/BRIEF.md
# Clock Recovery Lock Source Supervisor

This block is the digital supervisor beside a clock recovery loop. It decides each cycle whether the loop may follow the incoming serial data or must fall back to the local reference clock. It watches two things. The first is the deserialized 10-bit words, which it checks for a run of identical bits long enough to mean the signal is gone. The second is the recovered word clock, whose rate it measures against the reference over a fixed window.

Following the data is allowed only after one complete measurement window in which neither check failed. Either check failing drops the select at once, and the loop stays on the reference until another clean window has elapsed. The two failure flags are brought out separately so that a debug view can tell a dead line from an off-rate one. Everything runs on one system clock. The reference and recovered clocks arrive as single-cycle tick pulses.

Top module: `cdr_lock_supervisor`

## Requirements
- R1: After reset, `lock_data_o` is 0, `run_fail_o` is 0 and `freq_fail_o` is 1.
- R2: Bit 0 of each word is taken as received first. When a run of identical bits reaches `RUN_LIMIT` (default 120), counted across consecutive valid words, `run_fail_o` is 1 from the edge that accepts the word completing the run. A run one bit shorter leaves it at 0.
- R3: A run that starts partway into one word and ends partway into a later word is measured bit-exactly. This covers the trailing bits of the first word, any whole words in between, and the leading bits of the last word.
- R4: Runs of ones and runs of zeros are both detected.
- R5: A word presented with `word_vld_i` low has no effect on the run measurement or on `run_fail_o`.
- R6: A window spans `WIN_REF` reference ticks, counted from reset. The recovered ticks in the window are counted, including one that falls on the closing tick. The expected count E is `WIN_REF` when `div20_i`=0 and `2*WIN_REF` when `div20_i`=1. The tolerance T is floor(E*`TOL_PPM`/1e6). `freq_fail_o` is updated only at a window's close, and is 0 exactly when the count lies in [E-T, E+T].
- R7: `lock_data_o` goes to 1 only at a window close, and only when that whole window passed the frequency test and `run_fail_o` stayed 0 throughout it.
- R8: `lock_data_o` is never 1 while `run_fail_o` or `freq_fail_o` is 1. It falls on the same edge on which either flag rises.
- R9: After any failure the select stays on the reference through the rest of that window. A return to data lock needs a following complete clean window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div20_i | input | 1 | 0: one recovered tick per reference tick expected; 1: two |
| word_i | input | WORD_W | Deserialized word, bit 0 received first |
| word_vld_i | input | 1 | Qualifies `word_i` |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock period |
| rec_tick_i | input | 1 | One-cycle pulse per recovered word clock period |
| lock_data_o | output | 1 | 1: loop follows data; 0: loop follows reference |
| run_fail_o | output | 1 | Long identical run seen in the latest valid word |
| freq_fail_o | output | 1 | Last closed window was out of tolerance |

## Verification
The bench builds the block with `WIN_REF`=50 and `TOL_PPM`=20000, and keeps `RUN_LIMIT`=120 and 10-bit words. These values make a window 200 cycles long and give a tolerance of one tick in the divide-by-10 setting and two ticks in the divide-by-20 setting. The accept and reject edges on both sides of each window are therefore a single tick apart and cheap to reach. Keeping the 120-bit threshold at its real value lets the bench place runs of exactly 119 and 120 bits. Some of these runs straddle word boundaries mid-word, and some are made of ones.

// File: rtl/cls_pkg.sv
package cls_pkg;

    typedef enum logic {
        SRC_REF  = 1'b0,
        SRC_DATA = 1'b1
    } lock_src_e;

    typedef struct packed {
        lock_src_e src;
        logic      clean;
    } fsm_state_t;

endpackage

// File: rtl/cls_run_tracker.sv
module cls_run_tracker #(
    parameter int WORD_W    = 10,
    parameter int RUN_LIMIT = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_vld_i,
    output logic              run_fail_o
);
    localparam int SUM_W = $clog2(RUN_LIMIT + WORD_W + 1);
    localparam logic [SUM_W-1:0] LIMIT_V = SUM_W'(RUN_LIMIT);

    typedef struct packed {
        logic [SUM_W-1:0] cnt;
        logic             last_bit;
        logic             fail;
    } run_state_t;

    run_state_t st_d, st_q;
    logic [SUM_W-1:0] lead, trail, head;
    logic             cont;

    always_comb begin
        st_d = st_q;
        lead = SUM_W'(WORD_W);
        for (int i = WORD_W - 1; i >= 1; i--) begin
            if (word_i[i] != word_i[0]) lead = SUM_W'(i);
        end
        trail = SUM_W'(WORD_W);
        for (int i = 0; i < WORD_W - 1; i++) begin
            if (word_i[i] != word_i[WORD_W-1]) trail = SUM_W'(WORD_W - 1 - i);
        end
        cont = (word_i[0] == st_q.last_bit) && (st_q.cnt != '0);
        head = cont ? (st_q.cnt + lead) : lead;
        if (word_vld_i) begin
            st_d.fail     = (head >= LIMIT_V);
            st_d.last_bit = word_i[WORD_W-1];
            if (lead == SUM_W'(WORD_W)) begin
                st_d.cnt = (head > LIMIT_V) ? LIMIT_V : head;
            end else begin
                st_d.cnt = trail;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_fail_o = st_q.fail;

    AST_RUN_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT_V); // R2
    AST_IDLE_WORD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(word_vld_i) |-> ($stable(st_q.fail) && $stable(st_q.cnt))); // R5
endmodule

// File: rtl/cls_rate_window.sv
module cls_rate_window #(
    parameter int WIN_REF = 25000,
    parameter int TOL_PPM = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div20_i,
    input  logic ref_tick_i,
    input  logic rec_tick_i,
    output logic win_done_o,
    output logic win_pass_o,
    output logic freq_fail_o
);
    localparam int REF_W   = (WIN_REF > 2) ? $clog2(WIN_REF) : 1;
    localparam int REC_CAP = 4 * WIN_REF;
    localparam int REC_W   = $clog2(REC_CAP + 1);

    localparam longint EXP_A = longint'(WIN_REF);
    localparam longint EXP_B = 2 * longint'(WIN_REF);
    localparam longint TOL_A = EXP_A * longint'(TOL_PPM) / 64'd1000000;
    localparam longint TOL_B = EXP_B * longint'(TOL_PPM) / 64'd1000000;
    localparam logic [REC_W-1:0] LO_A = REC_W'(EXP_A - TOL_A);
    localparam logic [REC_W-1:0] HI_A = REC_W'(EXP_A + TOL_A);
    localparam logic [REC_W-1:0] LO_B = REC_W'(EXP_B - TOL_B);
    localparam logic [REC_W-1:0] HI_B = REC_W'(EXP_B + TOL_B);
    localparam logic [REC_W-1:0] CAP_V = REC_W'(REC_CAP);
    localparam logic [REF_W-1:0] LAST_REF = REF_W'(WIN_REF - 1);

    typedef struct packed {
        logic [REF_W-1:0] ref_cnt;
        logic [REC_W-1:0] rec_cnt;
        logic             fail;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [REC_W-1:0] total, lo, hi;

    always_comb begin
        st_d  = st_q;
        total = (st_q.rec_cnt == CAP_V) ? st_q.rec_cnt
                                        : st_q.rec_cnt + REC_W'(rec_tick_i);
        lo = div20_i ? LO_B : LO_A;
        hi = div20_i ? HI_B : HI_A;
        win_done_o = ref_tick_i && (st_q.ref_cnt == LAST_REF);
        win_pass_o = (total >= lo) && (total <= hi);
        if (win_done_o) begin
            st_d.ref_cnt = '0;
            st_d.rec_cnt = '0;
            st_d.fail    = !win_pass_o;
        end else begin
            st_d.ref_cnt = st_q.ref_cnt + REF_W'(ref_tick_i);
            st_d.rec_cnt = total;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ref_cnt <= '0;
            st_q.rec_cnt <= '0;
            st_q.fail    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_fail_o = st_q.fail;

    AST_FREQ_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_done_o) |-> $stable(st_q.fail)); // R6
    AST_REC_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rec_cnt <= CAP_V); // R6
endmodule

// File: rtl/cls_source_fsm.sv
module cls_source_fsm
    import cls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_fail_i,
    input  logic freq_fail_i,
    input  logic win_done_i,
    input  logic win_pass_i,
    output logic lock_data_o
);
    fsm_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.clean = win_done_i ? 1'b1 : (st_q.clean && !run_fail_i);
        if (run_fail_i) begin
            st_d.src = SRC_REF;
        end else if (win_done_i) begin
            st_d.src = (st_q.clean && win_pass_i) ? SRC_DATA : SRC_REF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src   <= SRC_REF;
            st_q.clean <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_data_o = (st_q.src == SRC_DATA) && !run_fail_i && !freq_fail_i;

    AST_PROMOTE_ON_CLEAN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.src == SRC_DATA) |-> $past(win_done_i && win_pass_i && st_q.clean)); // R7
    AST_RUN_FAIL_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
        run_fail_i |=> (st_q.src == SRC_REF)); // R9
    AST_DIRTY_WINDOW_HOLDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.clean && !win_done_i) |=> (st_q.src == SRC_REF)); // R9
endmodule

// File: rtl/cdr_lock_supervisor.sv
module cdr_lock_supervisor #(
    parameter int WORD_W    = 10,
    parameter int RUN_LIMIT = 120,
    parameter int WIN_REF   = 25000,
    parameter int TOL_PPM   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div20_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_vld_i,
    input  logic              ref_tick_i,
    input  logic              rec_tick_i,
    output logic              lock_data_o,
    output logic              run_fail_o,
    output logic              freq_fail_o
);
    logic win_done, win_pass;

    cls_run_tracker #(
        .WORD_W    (WORD_W),
        .RUN_LIMIT (RUN_LIMIT)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (word_i),
        .word_vld_i (word_vld_i),
        .run_fail_o (run_fail_o)
    );

    cls_rate_window #(
        .WIN_REF (WIN_REF),
        .TOL_PPM (TOL_PPM)
    ) u_rate (
        .clk         (clk),
        .rst_n       (rst_n),
        .div20_i     (div20_i),
        .ref_tick_i  (ref_tick_i),
        .rec_tick_i  (rec_tick_i),
        .win_done_o  (win_done),
        .win_pass_o  (win_pass),
        .freq_fail_o (freq_fail_o)
    );

    cls_source_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_fail_i  (run_fail_o),
        .freq_fail_i (freq_fail_o),
        .win_done_i  (win_done),
        .win_pass_i  (win_pass),
        .lock_data_o (lock_data_o)
    );

    AST_LOCK_EXCLUDES_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        lock_data_o |-> (!run_fail_o && !freq_fail_o)); // R8
endmodule

// File: tb/cdr_lock_supervisor_test.sv
module cdr_lock_supervisor_test;
    localparam int WIN = 50;
    localparam int CYC = 4 * WIN;
    localparam int ZST = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div20 = 1'b0;
    logic [9:0] word = 10'h2AA;
    logic vld = 1'b0;
    logic ref_t = 1'b0;
    logic rec_t = 1'b0;
    logic lock, rfail, ffail;
    int   n_chk = 0;
    int   n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    cdr_lock_supervisor #(.WIN_REF(WIN), .TOL_PPM(20000)) uut (
        .clk(clk), .rst_n(rst_n), .div20_i(div20), .word_i(word),
        .word_vld_i(vld), .ref_tick_i(ref_t), .rec_tick_i(rec_t),
        .lock_data_o(lock), .run_fail_o(rfail), .freq_fail_o(ffail)
    );

    typedef struct packed {
        logic       div;
        logic [7:0] nrec;
        logic [9:0] zw;
        logic [4:0] zlen;
        logic       zvld;
        logic [9:0] pre;
        logic [9:0] post;
        logic       xseen;
        logic       xff;
        logic       xlock;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'd50,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R6 R7 nominal
        '{1'b0, 8'd49,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R6 low edge
        '{1'b0, 8'd51,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R6 high edge
        '{1'b0, 8'd48,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b1, 1'b0}, // R6 R8 too slow
        '{1'b0, 8'd52,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b1, 1'b0}, // R6 too fast
        '{1'b0, 8'd50,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R9 recover
        '{1'b0, 8'd50,  10'h000, 5'd12, 1'b1, 10'h2AA, 10'h2AA, 1'b1, 1'b0, 1'b0}, // R2 R8 120 zeros
        '{1'b0, 8'd50,  10'h000, 5'd11, 1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R2 R9 111 zeros
        '{1'b0, 8'd50,  10'h000, 5'd11, 1'b1, 10'h001, 10'h3FE, 1'b1, 1'b0, 1'b0}, // R3 9+110+1
        '{1'b0, 8'd50,  10'h000, 5'd11, 1'b1, 10'h2AA, 10'h200, 1'b0, 1'b0, 1'b1}, // R3 110+9=119
        '{1'b0, 8'd50,  10'h3FF, 5'd12, 1'b1, 10'h2AA, 10'h2AA, 1'b1, 1'b0, 1'b0}, // R4 ones
        '{1'b0, 8'd50,  10'h3FF, 5'd11, 1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R4 short ones
        '{1'b0, 8'd50,  10'h000, 5'd20, 1'b0, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R5 invalid zeros
        '{1'b1, 8'd100, 10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}, // R6 div20
        '{1'b1, 8'd98,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1},
        '{1'b1, 8'd97,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b1, 1'b0},
        '{1'b1, 8'd103, 10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b1, 1'b0},
        '{1'b1, 8'd102, 10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1},
        '{1'b1, 8'd50,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b1, 1'b0},
        '{1'b0, 8'd50,  10'h000, 5'd0,  1'b1, 10'h2AA, 10'h2AA, 1'b0, 1'b0, 1'b1}  // R9 recover
    };

    logic seen, clash;

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic run_window(input vec_t v);
        seen  = 1'b0;
        clash = 1'b0;
        div20 = v.div;
        for (int i = 0; i < CYC; i++) begin
            @(negedge clk);
            if (rfail) seen = 1'b1;
            if (lock && (rfail || ffail)) clash = 1'b1;
            ref_t = ((i % 4) == 3);
            rec_t = (i < int'(v.nrec));
            vld   = 1'b1;
            word  = 10'h2AA;
            if (v.zlen != 0) begin
                if (i == ZST - 1) word = v.pre;
                else if (i >= ZST && i < ZST + int'(v.zlen)) begin
                    word = v.zw;
                    vld  = v.zvld;
                end else if (i == ZST + int'(v.zlen)) word = v.post;
            end
        end
        @(negedge clk);
        ref_t = 1'b0;
        rec_t = 1'b0;
        vld   = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        vld   = 1'b0;
        ref_t = 1'b0;
        rec_t = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1 lock", int'(lock), 0);
        check("R1 run_fail", int'(rfail), 0);
        check("R1 freq_fail", int'(ffail), 1);

        for (int k = 0; k < NV; k++) begin
            run_window(TBL[k]);
            // the closing edge is the last loop cycle; sampled one negedge later
            check($sformatf("R2/R3/R4/R5 run seen v%0d", k), int'(seen), int'(TBL[k].xseen));
            check($sformatf("R6 freq_fail v%0d", k), int'(ffail), int'(TBL[k].xff));
            check($sformatf("R7/R9 lock v%0d", k), int'(lock), int'(TBL[k].xlock));
            check($sformatf("R8 no lock with fail v%0d", k), int'(clash), 0);
        end

        // R1 mid-run reset, then R7 one clean window locks again
        do_reset();
        check("R1 lock after reset", int'(lock), 0);
        check("R1 freq_fail after reset", int'(ffail), 1);
        run_window(TBL[0]);
        check("R7 lock after first window", int'(lock), 1);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule